// File: doc/BRIEF.md
# Dual-Channel Memory Address Mapper

This block turns a flat physical byte address into a channel choice and an address local to that channel, for a memory controller with two channels, A and B. Each cycle it reads the programmed byte capacity of both channels and a flexible-mapping enable bit. From these it picks one of four mapping modes. Single-channel mode is used when only one channel holds memory. Interleaved mode is used when both channels are the same size; consecutive 64-byte cache lines then alternate between the channels. Stacked mode is used when the channels differ in size and flexible mapping is off; the address space then fills all of channel A first and continues at the base of channel B. The fourth mode is deferred. It applies when the sizes differ and flexible mapping is on, and in that case the mapping belongs to a separate region scheme.

A request is presented with a valid strobe. One clock later the block returns a registered result: a one-hot channel hit, the local address, an out-of-range flag and the active mode code. An address outside the populated space asserts no channel.

Top module: `dual_channel_mapper`

## Requirements
- R1: While reset is held, and in the first sample after it, `rsp_valid_o`, `hit_a_o`, `hit_b_o` and `out_of_range_o` are 0, `local_addr_o` is 0 and `mode_o` is 0.
- R2: `rsp_valid_o` equals the `req_valid_i` of the previous clock. `hit_a_o`, `hit_b_o` and `out_of_range_o` are 0 whenever `rsp_valid_o` is 0. All results appear one clock after the request.
- R3: `mode_o` is chosen as follows. It is 0 (single) unless both capacities are nonzero. With both nonzero it is 1 (interleaved) when the capacities are equal, 2 (stacked) when they differ and `flex_en_i` is 0, and 3 (deferred) when they differ and `flex_en_i` is 1.
- R4: In interleaved mode, address bit 6 selects the channel (0 means A, 1 means B). The local address is the request address with bit 6 removed: higher bits move down by one and bits 5:0 are kept. Capacities are multiples of 128 bytes.
- R5: In stacked mode, an address below `cap_a_i` hits channel A and the local address equals the request address.
- R6: In stacked mode, an address from `cap_a_i` up to but not including `cap_a_i + cap_b_i` hits channel B, with local address = address − `cap_a_i`.
- R7: An address at or above the populated span asserts `out_of_range_o`, asserts neither hit, and gives local address 0. The span is the sum of the capacities in interleaved and stacked mode, and the one nonzero capacity in single mode.
- R8: In single mode, an in-range address hits the channel whose capacity is nonzero, and the local address equals the request address.
- R9: In deferred mode every valid request is out of range.
- R10: With both capacities 0, the mode is 0 and every valid request is out of range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Request strobe |
| req_addr_i | input | ADDR_W | Flat physical byte address |
| cap_a_i | input | ADDR_W | Channel A capacity in bytes |
| cap_b_i | input | ADDR_W | Channel B capacity in bytes |
| flex_en_i | input | 1 | Flexible mapping enabled |
| rsp_valid_o | output | 1 | Result valid |
| hit_a_o | output | 1 | Request maps to channel A |
| hit_b_o | output | 1 | Request maps to channel B |
| local_addr_o | output | ADDR_W | Address within the selected channel |
| out_of_range_o | output | 1 | Address beyond populated memory |
| mode_o | output | 2 | Active mode code |

## Verification
Interleaved mode is driven with addresses where bit 6 is 0 and 1, with nonzero low bits and at the last byte. These cases separate the channel-select bit from its neighbours and confirm that the bit is removed rather than masked. Stacked mode is tried one byte either side of the channel A boundary and at the top of channel B, which exposes off-by-one compares and a missing subtraction. Single mode is exercised with each channel alone, and the empty and deferred configurations are covered as well; these show that the mode decision and the out-of-range span track the capacities. Cycles with the strobe low then check that no hit leaks out without a request.

// File: rtl/chmap_pkg.sv
package chmap_pkg;
    typedef enum logic [1:0] {
        MAP_SINGLE     = 2'd0,
        MAP_INTERLEAVE = 2'd1,
        MAP_STACKED    = 2'd2,
        MAP_DEFERRED   = 2'd3
    } map_mode_e;
endpackage

// File: rtl/chmap_mode_sel.sv
module chmap_mode_sel
    import chmap_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] cap_a,
    input  logic [ADDR_W-1:0] cap_b,
    input  logic              flex_en,
    output map_mode_e         mode,
    output logic [ADDR_W:0]   span,
    output logic              solo_b
);
    logic a_pop, b_pop;

    always_comb begin
        a_pop  = |cap_a;
        b_pop  = |cap_b;
        mode   = MAP_SINGLE;
        span   = '0;
        solo_b = 1'b0;
        if (a_pop && b_pop) begin
            if (cap_a == cap_b) begin
                mode = MAP_INTERLEAVE;
                span = {cap_a, 1'b0};
            end else if (flex_en) begin
                mode = MAP_DEFERRED;
                span = '0;
            end else begin
                mode = MAP_STACKED;
                span = {1'b0, cap_a} + {1'b0, cap_b};
            end
        end else begin
            mode   = MAP_SINGLE;
            span   = {1'b0, cap_a | cap_b};
            solo_b = !a_pop;
        end
    end
endmodule

// File: rtl/chmap_addr_split.sv
module chmap_addr_split
    import chmap_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int LINE_BITS = 6
) (
    input  map_mode_e         mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] cap_a,
    input  logic [ADDR_W:0]   span,
    input  logic              solo_b,
    output logic              hit_a,
    output logic              hit_b,
    output logic [ADDR_W-1:0] local_addr,
    output logic              oor
);
    localparam logic [ADDR_W-1:0] LOW_MASK =
        {{(ADDR_W-LINE_BITS){1'b0}}, {LINE_BITS{1'b1}}};

    logic [ADDR_W:0]   addr_ext;
    logic              in_span;
    logic [ADDR_W-1:0] squeezed;

    always_comb begin
        addr_ext   = {1'b0, addr};
        in_span    = addr_ext < span;
        squeezed   = ((addr >> (LINE_BITS + 1)) << LINE_BITS) | (addr & LOW_MASK);
        hit_a      = 1'b0;
        hit_b      = 1'b0;
        local_addr = '0;
        unique case (mode)
            MAP_SINGLE: if (in_span) begin
                hit_a      = !solo_b;
                hit_b      = solo_b;
                local_addr = addr;
            end
            MAP_INTERLEAVE: if (in_span) begin
                hit_a      = !addr[LINE_BITS];
                hit_b      = addr[LINE_BITS];
                local_addr = squeezed;
            end
            MAP_STACKED: begin
                if (addr_ext < {1'b0, cap_a}) begin
                    hit_a      = 1'b1;
                    local_addr = addr;
                end else if (in_span) begin
                    hit_b      = 1'b1;
                    local_addr = addr - cap_a;
                end
            end
            default: ;
        endcase
        oor = !(hit_a || hit_b);
    end
endmodule

// File: rtl/dual_channel_mapper.sv
module dual_channel_mapper
    import chmap_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [ADDR_W-1:0] cap_a_i,
    input  logic [ADDR_W-1:0] cap_b_i,
    input  logic              flex_en_i,
    output logic              rsp_valid_o,
    output logic              hit_a_o,
    output logic              hit_b_o,
    output logic [ADDR_W-1:0] local_addr_o,
    output logic              out_of_range_o,
    output logic [1:0]        mode_o
);
    localparam int LINE_BITS = $clog2(LINE_BYTES);

    typedef struct packed {
        logic              valid;
        logic              hit_a;
        logic              hit_b;
        logic [ADDR_W-1:0] local_addr;
        logic              oor;
        logic [1:0]        mode;
    } rsp_t;

    map_mode_e         mode_w;
    logic [ADDR_W:0]   span_w;
    logic              solo_b_w;
    logic              hit_a_w, hit_b_w, oor_w;
    logic [ADDR_W-1:0] local_w;
    rsp_t              rsp_d, rsp_q;

    chmap_mode_sel #(.ADDR_W(ADDR_W)) u_mode (
        .cap_a   (cap_a_i),
        .cap_b   (cap_b_i),
        .flex_en (flex_en_i),
        .mode    (mode_w),
        .span    (span_w),
        .solo_b  (solo_b_w)
    );

    chmap_addr_split #(.ADDR_W(ADDR_W), .LINE_BITS(LINE_BITS)) u_split (
        .mode       (mode_w),
        .addr       (req_addr_i),
        .cap_a      (cap_a_i),
        .span       (span_w),
        .solo_b     (solo_b_w),
        .hit_a      (hit_a_w),
        .hit_b      (hit_b_w),
        .local_addr (local_w),
        .oor        (oor_w)
    );

    always_comb begin
        rsp_d.valid      = req_valid_i;
        rsp_d.hit_a      = req_valid_i && hit_a_w;
        rsp_d.hit_b      = req_valid_i && hit_b_w;
        rsp_d.oor        = req_valid_i && oor_w;
        rsp_d.local_addr = req_valid_i ? local_w : '0;
        rsp_d.mode       = mode_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid_o    = rsp_q.valid;
    assign hit_a_o        = rsp_q.hit_a;
    assign hit_b_o        = rsp_q.hit_b;
    assign local_addr_o   = rsp_q.local_addr;
    assign out_of_range_o = rsp_q.oor;
    assign mode_o         = rsp_q.mode;

    // R2
    valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i |=> rsp_valid_o);
    // R2
    idle_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |=> !rsp_valid_o);
    // R2
    flags_need_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_a_o || hit_b_o || out_of_range_o) |-> rsp_valid_o);
    // R7
    one_channel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hit_a_o, hit_b_o}) && !(out_of_range_o && (hit_a_o || hit_b_o)));
    // R6
    b_local_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && mode_w == MAP_STACKED && hit_b_w) |=> local_addr_o < $past(cap_b_i));
    // R9
    deferred_unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && mode_o == 2'd3) |-> out_of_range_o);
endmodule

// File: tb/tb_dual_channel_mapper.sv
module tb_dual_channel_mapper;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;

    typedef struct packed {
        logic [3:0]    rq;
        logic [AW-1:0] cap_a;
        logic [AW-1:0] cap_b;
        logic          flex;
        logic [AW-1:0] addr;
        logic          ea;
        logic          eb;
        logic [AW-1:0] eloc;
        logic          eoor;
        logic [1:0]    emode;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VEC [NV] = '{
        // R4 interleaved, 4 KiB each
        '{4'd4, 32'h1000, 32'h1000, 1'b0, 32'h0000, 1'b1, 1'b0, 32'h000, 1'b0, 2'd1},
        '{4'd4, 32'h1000, 32'h1000, 1'b0, 32'h0040, 1'b0, 1'b1, 32'h000, 1'b0, 2'd1},
        '{4'd4, 32'h1000, 32'h1000, 1'b0, 32'h0080, 1'b1, 1'b0, 32'h040, 1'b0, 2'd1},
        '{4'd4, 32'h1000, 32'h1000, 1'b0, 32'h00C5, 1'b0, 1'b1, 32'h045, 1'b0, 2'd1},
        '{4'd4, 32'h1000, 32'h1000, 1'b0, 32'h1FFF, 1'b0, 1'b1, 32'hFFF, 1'b0, 2'd1},
        '{4'd4, 32'h1000, 32'h1000, 1'b1, 32'h0040, 1'b0, 1'b1, 32'h000, 1'b0, 2'd1},
        // R7 interleaved top
        '{4'd7, 32'h1000, 32'h1000, 1'b0, 32'h2000, 1'b0, 1'b0, 32'h000, 1'b1, 2'd1},
        // R5 / R6 stacked, A=4 KiB, B=12 KiB
        '{4'd5, 32'h1000, 32'h3000, 1'b0, 32'h0000, 1'b1, 1'b0, 32'h0000, 1'b0, 2'd2},
        '{4'd5, 32'h1000, 32'h3000, 1'b0, 32'h0FFF, 1'b1, 1'b0, 32'h0FFF, 1'b0, 2'd2},
        '{4'd6, 32'h1000, 32'h3000, 1'b0, 32'h1000, 1'b0, 1'b1, 32'h0000, 1'b0, 2'd2},
        '{4'd6, 32'h1000, 32'h3000, 1'b0, 32'h2345, 1'b0, 1'b1, 32'h1345, 1'b0, 2'd2},
        '{4'd6, 32'h1000, 32'h3000, 1'b0, 32'h3FFF, 1'b0, 1'b1, 32'h2FFF, 1'b0, 2'd2},
        '{4'd7, 32'h1000, 32'h3000, 1'b0, 32'h4000, 1'b0, 1'b0, 32'h0000, 1'b1, 2'd2},
        // R6 stacked, larger A
        '{4'd6, 32'h3000, 32'h1000, 1'b0, 32'h3040, 1'b0, 1'b1, 32'h0040, 1'b0, 2'd2},
        // R9 deferred
        '{4'd9, 32'h1000, 32'h3000, 1'b1, 32'h0100, 1'b0, 1'b0, 32'h0000, 1'b1, 2'd3},
        // R8 single on B, then on A
        '{4'd8, 32'h0000, 32'h2000, 1'b0, 32'h1FFF, 1'b0, 1'b1, 32'h1FFF, 1'b0, 2'd0},
        '{4'd8, 32'h0000, 32'h2000, 1'b0, 32'h0040, 1'b0, 1'b1, 32'h0040, 1'b0, 2'd0},
        '{4'd7, 32'h0000, 32'h2000, 1'b0, 32'h2000, 1'b0, 1'b0, 32'h0000, 1'b1, 2'd0},
        '{4'd8, 32'h0800, 32'h0000, 1'b1, 32'h07FF, 1'b1, 1'b0, 32'h07FF, 1'b0, 2'd0},
        // R10 empty
        '{4'd10, 32'h0000, 32'h0000, 1'b0, 32'h0000, 1'b0, 1'b0, 32'h0000, 1'b1, 2'd0},
        // R3 mode only follows capacities
        '{4'd3, 32'h2000, 32'h1000, 1'b0, 32'h2000, 1'b0, 1'b1, 32'h0000, 1'b0, 2'd2}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid_i = 1'b0;
    logic [AW-1:0] req_addr_i = '0;
    logic [AW-1:0] cap_a_i = '0;
    logic [AW-1:0] cap_b_i = '0;
    logic          flex_en_i = 1'b0;
    logic          rsp_valid_o, hit_a_o, hit_b_o, out_of_range_o;
    logic [AW-1:0] local_addr_o;
    logic [1:0]    mode_o;

    int  tests = 0;
    int  fails = 0;
    bit  done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_channel_mapper #(.ADDR_W(AW), .LINE_BYTES(64)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .req_addr_i(req_addr_i),
        .cap_a_i(cap_a_i), .cap_b_i(cap_b_i), .flex_en_i(flex_en_i),
        .rsp_valid_o(rsp_valid_o), .hit_a_o(hit_a_o), .hit_b_o(hit_b_o),
        .local_addr_o(local_addr_o), .out_of_range_o(out_of_range_o), .mode_o(mode_o)
    );

    task automatic check(input int rq, input logic ev, input logic ea, input logic eb,
                         input logic [AW-1:0] eloc, input logic eoor, input logic [1:0] emode);
        tests++;
        if (rsp_valid_o !== ev || hit_a_o !== ea || hit_b_o !== eb ||
            local_addr_o !== eloc || out_of_range_o !== eoor || mode_o !== emode) begin
            fails++;
            $display("FAIL R%0d: got v=%b a=%b b=%b loc=%h oor=%b mode=%0d, exp v=%b a=%b b=%b loc=%h oor=%b mode=%0d",
                     rq, rsp_valid_o, hit_a_o, hit_b_o, local_addr_o, out_of_range_o, mode_o,
                     ev, ea, eb, eloc, eoor, emode);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        for (int c = 0; c < 20000; c++) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: got timeout, exp completion");
        finish_run();
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        check(1, 1'b0, 1'b0, 1'b0, '0, 1'b0, 2'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(1, 1'b0, 1'b0, 1'b0, '0, 1'b0, 2'd0);

        for (int i = 0; i < NV; i++) begin
            cap_a_i     = VEC[i].cap_a;
            cap_b_i     = VEC[i].cap_b;
            flex_en_i   = VEC[i].flex;
            req_addr_i  = VEC[i].addr;
            req_valid_i = 1'b1;
            @(negedge clk);
            check(int'(VEC[i].rq), 1'b1, VEC[i].ea, VEC[i].eb, VEC[i].eloc,
                  VEC[i].eoor, VEC[i].emode);
        end

        // R2: strobe low with an in-range address -> no hit, no flag
        cap_a_i = 32'h1000; cap_b_i = 32'h1000; flex_en_i = 1'b0;
        req_addr_i = 32'h0040; req_valid_i = 1'b0;
        @(negedge clk);
        check(2, 1'b0, 1'b0, 1'b0, '0, 1'b0, 2'd1);
        // R2: strobe low with an out-of-range address -> no flag
        req_addr_i = 32'h9000;
        @(negedge clk);
        check(2, 1'b0, 1'b0, 1'b0, '0, 1'b0, 2'd1);
        // R2: one-cycle latency, back-to-back requests
        req_valid_i = 1'b1; req_addr_i = 32'h0000;
        @(negedge clk);
        check(2, 1'b1, 1'b1, 1'b0, 32'h0, 1'b0, 2'd1);
        req_addr_i = 32'h00C0;
        @(negedge clk);
        check(2, 1'b1, 1'b0, 1'b1, 32'h40, 1'b0, 2'd1);
        // R3: deferred only when sizes differ and flex set
        cap_b_i = 32'h0800; flex_en_i = 1'b1; req_addr_i = 32'h0;
        @(negedge clk);
        check(3, 1'b1, 1'b0, 1'b0, 32'h0, 1'b1, 2'd3);
        // R1: reset mid-run clears outputs
        rst_n = 1'b0;
        @(negedge clk);
        check(1, 1'b0, 1'b0, 1'b0, '0, 1'b0, 2'd0);
        rst_n = 1'b1; req_valid_i = 1'b0;
        @(negedge clk);
        finish_run();
    end
endmodule